// File: doc/BRIEF.md
# Reload-Compare PWM Generator

This block produces a pulse-width-modulated output from a reloadable down counter and a compare value. The counter steps down once per count strobe. The strobe is a single-cycle enable that marks one period of the external count source. When the counter leaves zero it reloads the period value `n` and emits a one-cycle underflow pulse. The output is active while the counter value is at or above the compare value `m`. Each period is therefore `n+1` strobes long, and the output is active for `n-m+1` of them. The duty is `(n-m+1)/(n+1)`, and each period starts with its active phase.

Software loads both values through an 8-bit byte write port. The two compare bytes go first, in either order. The timer low byte follows, and then the timer high byte. The high byte write commits `n` and `m` together as one set. A write sequence that is incomplete or out of order commits nothing. The byte address for the counter extension is accepted but discarded, so the counter always runs 16 bits wide.

A controller state machine has two states. In `CT_IDLE` the counter does not run and the output is low. The transition `CT_IDLE -> CT_RUN` happens on the first commit, which loads the counter at once. `CT_RUN` holds until reset. A write sequencer tracks the byte order through five states:

- `SQ_EMPTY`: no byte of the current set has been written.
- `SQ_CMP_LO`: only the compare low byte has been written.
- `SQ_CMP_HI`: only the compare high byte has been written.
- `SQ_CMP_BOTH`: both compare bytes have been written.
- `SQ_TMR_LO`: both compare bytes and then the timer low byte have been written.

The sequencer moves between them as follows:

- A compare byte write moves `SQ_EMPTY` to the matching one-byte state.
- Writing the missing compare byte in a one-byte state moves to `SQ_CMP_BOTH`.
- A compare byte write in `SQ_TMR_LO` restarts the sequence in that byte's one-byte state.
- A timer low write moves `SQ_CMP_BOTH` to `SQ_TMR_LO`. In `SQ_TMR_LO` it stays there. In any other state it returns to `SQ_EMPTY`.
- A timer high write always returns to `SQ_EMPTY`. It commits the set only when it is made from `SQ_TMR_LO`.

Top module: `pwm_cmp_gen`

## Requirements
- R1: After synchronous reset, `pwm_out` and `uf_pulse` are 0. The counter does not run, and both outputs stay 0 whatever `cnt_stb` does, until the first set of values is committed.
- R2: While running with period value `n`, `uf_pulse` is high for exactly one cycle every `n+1` strobes. It is raised by the clock edge of the strobe that finds the counter at zero, and the same edge reloads `n`.
- R3: While running, `pwm_out` is high exactly when the counter value is at or above `m`. This gives `n-m+1` active strobes per period, starting at the reload.
- R4: With `m = 0` the output is active for the whole period. With `m > n` it is inactive for the whole period.
- R5: The byte addresses are 0 for compare low, 1 for compare high, 2 for the extension, 3 for timer low and 4 for timer high. A set `n = {timer high, timer low}`, `m = {compare high, compare low}` is committed by a timer high write only after both compare bytes, in either order, and then the timer low byte.
- R6: A timer high write that does not follow that sequence commits nothing, and the running period and duty are unchanged.
- R7: The first commit after reset starts counting from the new `n` on the next clock. A later commit takes effect, with `n` and `m` together, at the next reload. If two sets are committed within one period, the later one is used.
- R8: Writes to the extension address change neither the sequence nor the loaded values. The counter always behaves as a 16-bit counter.
- R9: In a cycle without a strobe, the counter holds its value and `uf_pulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_stb | input | 1 | Count strobe, one pulse per count-source period |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 3 | Byte address (0 compare low, 1 compare high, 2 extension, 3 timer low, 4 timer high) |
| wr_data | input | DATA_W | Write byte |
| pwm_out | output | 1 | PWM output |
| uf_pulse | output | 1 | One-cycle underflow pulse at each reload |

## Verification
The bench builds the block with its default 8-bit bytes, which gives a 16-bit counter and compare value. Most periods are kept short so that many complete periods fit into a run. These short periods cover `n = 0` with an underflow on every strobe, `m = 0`, `m > n`, and a value pair that uses both high bytes (`n = 259`, `m = 256`). The strobe is driven continuously, every other cycle, and held low for long stretches. This exercises holding, reload on a sparse strobe, and commits that land partway through a period.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_EXT    = 3'd2;
    localparam logic [ADDR_W-1:0] A_TMR_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_TMR_HI = 3'd4;

    typedef enum logic [2:0] {
        SQ_EMPTY,
        SQ_CMP_LO,
        SQ_CMP_HI,
        SQ_CMP_BOTH,
        SQ_TMR_LO
    } seq_state_e;

    typedef enum logic {
        CT_IDLE,
        CT_RUN
    } cnt_state_e;

endpackage

// File: rtl/pwm_wr_seq.sv
module pwm_wr_seq
    import pwm_cmp_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int VAL_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic [VAL_W-1:0]  new_n,
    output logic [VAL_W-1:0]  new_m
);

    seq_state_e        seq_q, seq_d;
    logic [DATA_W-1:0] cmp_lo_q, cmp_hi_q, tmr_lo_q;

    logic wr_cl, wr_ch, wr_tl, wr_th;

    always_comb begin
        wr_cl = wr_en && (wr_addr == A_CMP_LO);
        wr_ch = wr_en && (wr_addr == A_CMP_HI);
        wr_tl = wr_en && (wr_addr == A_TMR_LO);
        wr_th = wr_en && (wr_addr == A_TMR_HI);
    end

    // next-state logic of the byte-order tracker
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SQ_EMPTY: begin
                if (wr_cl)      seq_d = SQ_CMP_LO;
                else if (wr_ch) seq_d = SQ_CMP_HI;
                else if (wr_tl || wr_th) seq_d = SQ_EMPTY;
            end
            SQ_CMP_LO: begin
                if (wr_ch)      seq_d = SQ_CMP_BOTH;
                else if (wr_cl) seq_d = SQ_CMP_LO;
                else if (wr_tl || wr_th) seq_d = SQ_EMPTY;
            end
            SQ_CMP_HI: begin
                if (wr_cl)      seq_d = SQ_CMP_BOTH;
                else if (wr_ch) seq_d = SQ_CMP_HI;
                else if (wr_tl || wr_th) seq_d = SQ_EMPTY;
            end
            SQ_CMP_BOTH: begin
                if (wr_tl)      seq_d = SQ_TMR_LO;
                else if (wr_th) seq_d = SQ_EMPTY;
            end
            SQ_TMR_LO: begin
                if (wr_cl)      seq_d = SQ_CMP_LO;
                else if (wr_ch) seq_d = SQ_CMP_HI;
                else if (wr_th) seq_d = SQ_EMPTY;
            end
            default: seq_d = SQ_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SQ_EMPTY;
        else     seq_q <= seq_d;
    end

    // byte staging; the extension address has no storage
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
            tmr_lo_q <= '0;
        end else begin
            if (wr_cl) cmp_lo_q <= wr_data;
            if (wr_ch) cmp_hi_q <= wr_data;
            if (wr_tl) tmr_lo_q <= wr_data;
        end
    end

    always_comb begin
        commit = wr_th && (seq_q == SQ_TMR_LO);
        new_n  = {wr_data, tmr_lo_q};
        new_m  = {cmp_hi_q, cmp_lo_q};
    end

    assert_ext_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_EXT) |=> $stable(seq_q) && $stable(cmp_lo_q)
                                        && $stable(cmp_hi_q) && $stable(tmr_lo_q));

    assert_commit_resets_seq_R5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (seq_q == SQ_EMPTY));

endmodule

// File: rtl/pwm_reload_ctl.sv
module pwm_reload_ctl #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             commit,
    input  logic [VAL_W-1:0] new_n,
    input  logic [VAL_W-1:0] new_m,
    input  logic             apply,
    output logic [VAL_W-1:0] ld_n,
    output logic [VAL_W-1:0] ld_m,
    output logic [VAL_W-1:0] act_n,
    output logic [VAL_W-1:0] act_m
);

    logic             pend_q;
    logic [VAL_W-1:0] pend_n_q, pend_m_q;

    // a set committed this cycle wins over an older pending set
    always_comb begin
        if (commit) begin
            ld_n = new_n;
            ld_m = new_m;
        end else if (pend_q) begin
            ld_n = pend_n_q;
            ld_m = pend_m_q;
        end else begin
            ld_n = act_n;
            ld_m = act_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            pend_n_q <= '0;
            pend_m_q <= '0;
            act_n    <= '0;
            act_m    <= '0;
        end else begin
            if (apply) begin
                act_n  <= ld_n;
                act_m  <= ld_m;
                pend_q <= 1'b0;
            end else if (commit && running) begin
                pend_q   <= 1'b1;
                pend_n_q <= new_n;
                pend_m_q <= new_m;
            end
        end
    end

    assert_pend_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        apply |=> !pend_q);

    assert_pairs_together_R7: assert property (@(posedge clk) disable iff (rst)
        (!apply) |=> $stable(act_n) && $stable(act_m));

endmodule

// File: rtl/pwm_dn_core.sv
module pwm_dn_core
    import pwm_cmp_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_stb,
    input  logic             commit,
    input  logic [VAL_W-1:0] ld_n,
    input  logic [VAL_W-1:0] ld_m,
    input  logic [VAL_W-1:0] act_n,
    input  logic [VAL_W-1:0] act_m,
    output logic             running,
    output logic             apply,
    output logic             pwm_q,
    output logic             uf_q
);

    cnt_state_e       st_q, st_d;
    logic [VAL_W-1:0] cnt_q, cnt_d, m_next;
    logic             start, reload;

    always_comb begin
        running = (st_q == CT_RUN);
        start   = (st_q == CT_IDLE) && commit;
        reload  = running && cnt_stb && (cnt_q == '0);
        apply   = start || reload;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CT_IDLE: if (start) st_d = CT_RUN;
            CT_RUN:  st_d = CT_RUN;
            default: st_d = CT_IDLE;
        endcase
    end

    always_comb begin
        if (apply)                cnt_d = ld_n;
        else if (running && cnt_stb) cnt_d = cnt_q - 1'b1;
        else                      cnt_d = cnt_q;
        m_next = apply ? ld_m : act_m;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
            uf_q  <= 1'b0;
        end else begin
            pwm_q <= (st_d == CT_RUN) && (cnt_d >= m_next);
            uf_q  <= reload;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == CT_IDLE) |-> (!pwm_q && !uf_q));

    assert_uf_loads_n_R2: assert property (@(posedge clk) disable iff (rst)
        uf_q |-> (cnt_q == act_n));

    assert_cnt_within_n_R2: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt_q <= act_n));

    assert_full_duty_R4: assert property (@(posedge clk) disable iff (rst)
        (running && act_m == '0) |-> pwm_q);

    assert_hold_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (running && !cnt_stb) |=> ($stable(cnt_q) && !uf_q));

endmodule

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen
    import pwm_cmp_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int VAL_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_stb,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              uf_pulse
);

    logic             commit, running, apply;
    logic [VAL_W-1:0] new_n, new_m, ld_n, ld_m, act_n, act_m;

    pwm_wr_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .new_n   (new_n),
        .new_m   (new_m)
    );

    pwm_reload_ctl #(.VAL_W(VAL_W)) u_rld (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .commit  (commit),
        .new_n   (new_n),
        .new_m   (new_m),
        .apply   (apply),
        .ld_n    (ld_n),
        .ld_m    (ld_m),
        .act_n   (act_n),
        .act_m   (act_m)
    );

    pwm_dn_core #(.VAL_W(VAL_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .cnt_stb (cnt_stb),
        .commit  (commit),
        .ld_n    (ld_n),
        .ld_m    (ld_m),
        .act_n   (act_n),
        .act_m   (act_m),
        .running (running),
        .apply   (apply),
        .pwm_q   (pwm_out),
        .uf_q    (uf_pulse)
    );

    assert_uf_single_R2: assert property (@(posedge clk) disable iff (rst)
        (uf_pulse && !$past(rst)) |-> !$past(uf_pulse) || $past(cnt_stb));

endmodule

// File: tb/sim_pwm_cmp_gen.sv
module sim_pwm_cmp_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out, uf_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pwm_cmp_gen #(.DATA_W(8)) u0 (
        .clk      (clk),
        .rst      (rst),
        .cnt_stb  (cnt_stb),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out),
        .uf_pulse (uf_pulse)
    );

    // behavioural reference model
    bit          g_lo, g_hi, g_tok, m_run, m_pend, e_pwm, e_uf;
    logic [7:0]  s_cl, s_ch, s_tl;
    int unsigned m_cnt, a_n, a_m, p_n, p_m;

    always @(posedge clk) begin : model
        bit c;
        int unsigned nn, nm;
        if (rst) begin
            g_lo = 0; g_hi = 0; g_tok = 0; m_run = 0; m_pend = 0;
            e_pwm = 0; e_uf = 0; s_cl = 0; s_ch = 0; s_tl = 0;
            m_cnt = 0; a_n = 0; a_m = 0; p_n = 0; p_m = 0;
        end else begin
            c  = 0;
            nn = {wr_data, s_tl};
            nm = {s_ch, s_cl};
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin s_cl = wr_data; if (g_tok) begin g_hi = 0; g_tok = 0; end g_lo = 1; end
                    3'd1: begin s_ch = wr_data; if (g_tok) begin g_lo = 0; g_tok = 0; end g_hi = 1; end
                    3'd3: begin
                        s_tl = wr_data;
                        if (g_lo && g_hi) g_tok = 1;
                        else begin g_lo = 0; g_hi = 0; g_tok = 0; end
                    end
                    3'd4: begin c = g_tok; g_lo = 0; g_hi = 0; g_tok = 0; end
                    default: ;
                endcase
            end
            e_uf = 0;
            if (!m_run) begin
                if (c) begin m_run = 1; m_cnt = nn; a_n = nn; a_m = nm; m_pend = 0; end
            end else if (cnt_stb && m_cnt == 0) begin
                if (c) begin a_n = nn; a_m = nm; end
                else if (m_pend) begin a_n = p_n; a_m = p_m; end
                m_cnt = a_n; m_pend = 0; e_uf = 1;
            end else begin
                if (c) begin m_pend = 1; p_n = nn; p_m = nm; end
                if (cnt_stb) m_cnt = m_cnt - 1;
            end
            e_pwm = m_run && (m_cnt >= a_m);
        end
    end

    // every-cycle comparison (R3 duty and R2 underflow, R7 timing of updates)
    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (pwm_out !== e_pwm || uf_pulse !== e_uf) begin
                n_fail++;
                $display("FAIL R3/R2/R7 cycle compare: pwm=%0b uf=%0b expected pwm=%0b uf=%0b",
                         pwm_out, uf_pulse, e_pwm, e_uf);
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_set(int n, int m, bit hi_first);
        if (hi_first) begin wr(3'd1, m[15:8]); wr(3'd0, m[7:0]); end
        else          begin wr(3'd0, m[7:0]);  wr(3'd1, m[15:8]); end
        wr(3'd3, n[7:0]);
        wr(3'd4, n[15:8]);
    endtask

    // strobe held high; window starts at an underflow
    task automatic measure(int n, int m, string tag);
        int hi;
        int guard;
        int exp_hi;
        exp_hi = (m > n) ? 0 : n - m + 1;
        guard = 0;
        @(negedge clk);
        while (!uf_pulse && guard < 2000) begin @(negedge clk); guard++; end
        hi = 0;
        for (int i = 0; i <= n; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
        check(uf_pulse == 1'b1, {tag, " R2 period end underflow"}, int'(uf_pulse), 1);
        check(hi == exp_hi, {tag, " R3 active count"}, hi, exp_hi);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out == 0 && uf_pulse == 0, "R1 reset outputs", int'({pwm_out, uf_pulse}), 0);

        // R1: strobes without any commit do nothing
        cnt_stb = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (pwm_out || uf_pulse) seen++;
            end
            check(seen == 0, "R1 idle before commit", seen, 0);
        end

        // R5: compare high written first
        program_set(9, 3, 1'b1);
        measure(9, 3, "n9m3");
        measure(9, 3, "n9m3 repeat");

        // R7: new set mid-period, R4 full duty
        program_set(5, 0, 1'b0);
        measure(5, 0, "R4 m0");

        // R4: compare above period
        program_set(4, 7, 1'b1);
        measure(4, 7, "R4 m>n");

        // R6: out-of-order sequences do not commit
        wr(3'd3, 8'd1);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'd0);
        wr(3'd3, 8'd2);
        wr(3'd4, 8'd0);
        measure(4, 7, "R6 no commit");

        // R8: extension write inside a sequence is ignored
        wr(3'd0, 8'd2);
        wr(3'd1, 8'd0);
        wr(3'd2, 8'd3);
        wr(3'd3, 8'd3);
        wr(3'd4, 8'd0);
        measure(3, 2, "R8 ext ignored");

        // R9: strobe held low
        begin
            logic p0;
            int chg;
            @(negedge clk);
            cnt_stb = 1'b0;
            @(negedge clk);
            p0  = pwm_out;
            chg = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (pwm_out !== p0 || uf_pulse) chg++;
            end
            check(chg == 0, "R9 hold without strobe", chg, 0);
        end

        // sparse strobe, checked by the cycle model
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            cnt_stb = i[0];
        end
        cnt_stb = 1'b1;

        // R7: two commits inside one period, the later one is used
        program_set(200, 10, 1'b0);
        program_set(6, 2, 1'b1);
        measure(6, 2, "R7 later set wins");

        // both high bytes in use
        program_set(259, 256, 1'b0);
        measure(259, 256, "R5 wide values");

        // n = 0: underflow on every strobe
        program_set(0, 0, 1'b1);
        measure(0, 0, "R2 n0");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule